// File: doc/BRIEF.md
# Logarithmic Number Format Arithmetic Unit

This unit works with a compact logarithmic number format. It converts short signed fixed-point integers into that format and back, and it multiplies or adds two log-format operands without leaving the log domain. A product is the sum of the two log magnitudes. A sum takes the larger operand and applies a correction taken from a table indexed by the difference between the magnitudes. For fixed to log conversion a leading-one search finds the integer part of the logarithm, and a tiny table maps the mantissa bits below the leading one to the fraction. For log to fixed conversion a tiny antilog table feeds a barrel shift.

Each log word has three parts. Bit 7 is the sign and bit 6 is a zero flag. Bits 5:0 hold the magnitude code m, which is three integer bits above three fraction bits. The value is ±2^(m/8). All operations go through a pipeline with a fixed latency of two clock cycles, and a new operation may be issued on every cycle. The widths are parameters. The defaults are a 15-bit fixed-point side and an 8-bit log word.

Top module: `logfmt_alu`

## Requirements
- R1: An operation sampled with `in_valid` high at a rising edge produces its result, with `out_valid` high, after the second following rising edge. `out_valid` stays low two edges after a cycle with `in_valid` low.
- R2: Log word layout: bit 7 is the sign, bit 6 is the zero flag, bits 5:0 are the magnitude code (integer part in bits 5:3, fraction in bits 2:0). Every zero result is emitted as 8'h40. An input with bit 6 set counts as zero, whatever its other bits hold.
- R3: Op 0 (fixed to log) takes the two's-complement `fix_in`. Zero gives 8'h40. Otherwise p is the leading-one index of |x|, k is the three bits below that leading one (zero-filled), and the code is 8p + round(8·log2(1+k/8)) with the sign of x. Any |x| ≥ 256 saturates to magnitude 63.
- R4: Op 1 (log to fixed) decodes `log_a` as ±floor((256 + round(256·(2^(f/8) − 1)))·2^i / 256), with i = bits 5:3 and f = bits 2:0. A zero-flagged input gives 0.
- R5: Op 2 (multiply) gives 8'h40 if either operand is zero. Otherwise the sign is the XOR of the two signs and the magnitude is the sum of the magnitudes, saturated at 63.
- R6: Op 3 (add) with equal signs gives the larger magnitude plus round(8·log2(1+2^(−d/8))), saturated at 63, where d is the difference of the magnitudes. The sign is kept.
- R7: Op 3 with opposite signs gives 8'h40 when d = 0. Otherwise it gives the larger magnitude plus round(8·log2(1−2^(−d/8))) with the sign of the larger operand. A result below code 0 becomes 8'h40.
- R8: Op 3 with one zero operand returns the other operand unchanged. With two zero operands it returns 8'h40.
- R9: The output a given op does not use is zero: `fix_out` for ops 0, 2 and 3, and `log_out` for op 1.
- R10: While reset is held and right after it is released, `out_valid`, `log_out` and `fix_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request in this cycle |
| op | input | 2 | 0 fixed to log, 1 log to fixed, 2 multiply, 3 add |
| fix_in | input | 15 | Signed fixed-point operand for op 0 |
| log_a | input | 8 | First log operand (ops 1, 2, 3) |
| log_b | input | 8 | Second log operand (ops 2, 3) |
| out_valid | output | 1 | Result valid |
| log_out | output | 8 | Log-format result |
| fix_out | output | 15 | Signed fixed-point result |

## Verification
Every result is due exactly two rising edges after its operation is sampled, whatever the op. The bench drives inputs at falling edges and keeps a two-slot queue of expected values, so the output seen at a falling edge is compared against the operation driven two falling edges earlier. This lets the sweeps issue one operation per cycle. These sweeps cover every 15-bit input, every log word, and every pair of canonical log operands for multiply and add. A separate directed test follows a single isolated operation cycle by cycle, to confirm that `out_valid` rises on the second edge and is low on the first and third.

// File: rtl/logfmt_pkg.sv
package logfmt_pkg;

   typedef enum logic [1:0] {
      OP_TO_LOG = 2'd0,
      OP_TO_FIX = 2'd1,
      OP_MUL    = 2'd2,
      OP_ADD    = 2'd3
   } lf_op_e;

   // nearest integer, halves rounded upward
   function automatic int lf_round(input real x);
      return $rtoi($floor(x + 0.5));
   endfunction

   function automatic real lf_log2(input real x);
      return $ln(x) / $ln(2.0);
   endfunction

   function automatic real lf_exp2(input real x);
      return $exp(x * $ln(2.0));
   endfunction

   // fraction code for mantissa bits k below the leading one
   function automatic int lf_enc_entry(input int k, input int fw);
      real scale;
      scale = real'(1 << fw);
      return lf_round(scale * lf_log2(1.0 + real'(k) / scale));
   endfunction

   // antilog mantissa (without hidden one) for fraction code f
   function automatic int lf_dec_entry(input int f, input int fw, input int aw);
      return lf_round(real'(1 << aw) * (lf_exp2(real'(f) / real'(1 << fw)) - 1.0));
   endfunction

   // correction added for equal-sign sums, indexed by magnitude difference
   function automatic int lf_sum_entry(input int d, input int fw);
      real scale;
      scale = real'(1 << fw);
      return lf_round(scale * lf_log2(1.0 + lf_exp2(-real'(d) / scale)));
   endfunction

   // correction subtracted for opposite-sign sums (d = 0 handled apart)
   function automatic int lf_dif_entry(input int d, input int fw);
      real scale;
      scale = real'(1 << fw);
      if (d == 0) return 0;
      return -lf_round(scale * lf_log2(1.0 - lf_exp2(-real'(d) / scale)));
   endfunction

endpackage

// File: rtl/logfmt_to_log.sv
module logfmt_to_log #(
   parameter int FIX_W  = 15,
   parameter int INT_W  = 3,
   parameter int FRAC_W = 3
) (
   input  logic [FIX_W-1:0]          fix_i,
   output logic [INT_W+FRAC_W+1:0]   log_o
);
   import logfmt_pkg::*;

   localparam int MAG_W   = INT_W + FRAC_W;
   localparam int P_W     = $clog2(FIX_W);
   localparam int NFRAC   = 1 << FRAC_W;
   localparam int INT_MAX = (1 << INT_W) - 1;

   logic [FRAC_W-1:0] enc_tbl [NFRAC];

   for (genvar g = 0; g < NFRAC; g++) begin : g_enc
      assign enc_tbl[g] = FRAC_W'(lf_enc_entry(g, FRAC_W));
   end

   logic [FIX_W-1:0]  mag;
   logic [P_W-1:0]    lead_pos;
   logic [FRAC_W-1:0] frac_idx;
   logic              neg;

   assign neg = fix_i[FIX_W-1];
   assign mag = neg ? (~fix_i + 1'b1) : fix_i;

   // leading-one detector: highest set bit wins
   always_comb begin
      lead_pos = '0;
      for (int i = 0; i < FIX_W; i++) begin
         if (mag[i]) lead_pos = P_W'(i);
      end
   end

   // shifter brings the bits below the leading one into the index
   assign frac_idx = FRAC_W'({mag, {FRAC_W{1'b0}}} >> lead_pos);

   always_comb begin
      if (mag == '0) begin
         log_o = {1'b0, 1'b1, {MAG_W{1'b0}}};
      end else if (lead_pos > P_W'(INT_MAX)) begin
         log_o = {neg, 1'b0, {MAG_W{1'b1}}};
      end else begin
         log_o = {neg, 1'b0, lead_pos[INT_W-1:0], enc_tbl[frac_idx]};
      end
   end

endmodule

// File: rtl/logfmt_to_fix.sv
module logfmt_to_fix #(
   parameter int FIX_W  = 15,
   parameter int INT_W  = 3,
   parameter int FRAC_W = 3,
   parameter int ANTI_W = 8
) (
   input  logic [INT_W+FRAC_W+1:0] log_i,
   output logic [FIX_W-1:0]        fix_o
);
   import logfmt_pkg::*;

   localparam int MAG_W  = INT_W + FRAC_W;
   localparam int NFRAC  = 1 << FRAC_W;
   localparam int NI     = 1 << INT_W;
   localparam int WIDE_W = ANTI_W + NI;

   logic [ANTI_W-1:0] dec_tbl [NFRAC];

   for (genvar g = 0; g < NFRAC; g++) begin : g_dec
      assign dec_tbl[g] = ANTI_W'(lf_dec_entry(g, FRAC_W, ANTI_W));
   end

   logic              sgn, zflag;
   logic [INT_W-1:0]  ipart;
   logic [FRAC_W-1:0] fpart;
   logic [ANTI_W:0]   mant;
   logic [FIX_W-1:0]  mag_fix;

   assign sgn   = log_i[MAG_W+1];
   assign zflag = log_i[MAG_W];
   assign ipart = log_i[MAG_W-1:FRAC_W];
   assign fpart = log_i[FRAC_W-1:0];
   assign mant  = {1'b1, dec_tbl[fpart]};

   // barrel shift by the integer part, then drop the table precision
   assign mag_fix = FIX_W'((WIDE_W'(mant) << ipart) >> ANTI_W);

   always_comb begin
      if (zflag)    fix_o = '0;
      else if (sgn) fix_o = ~mag_fix + 1'b1;
      else          fix_o = mag_fix;
   end

endmodule

// File: rtl/logfmt_arith.sv
module logfmt_arith #(
   parameter int INT_W  = 3,
   parameter int FRAC_W = 3
) (
   input  logic                     do_add,
   input  logic [INT_W+FRAC_W+1:0]  a_i,
   input  logic [INT_W+FRAC_W+1:0]  b_i,
   output logic [INT_W+FRAC_W+1:0]  res_o
);
   import logfmt_pkg::*;

   localparam int MAG_W   = INT_W + FRAC_W;
   localparam int LOG_W   = MAG_W + 2;
   localparam int NMAG    = 1 << MAG_W;
   localparam int C_W     = MAG_W + 2;
   localparam int MAG_MAX = NMAG - 1;
   localparam logic [LOG_W-1:0] ZERO_W = {1'b0, 1'b1, {MAG_W{1'b0}}};

   logic [C_W-1:0] sum_tbl [NMAG];
   logic [C_W-1:0] dif_tbl [NMAG];

   for (genvar g = 0; g < NMAG; g++) begin : g_corr
      assign sum_tbl[g] = C_W'(lf_sum_entry(g, FRAC_W));
      assign dif_tbl[g] = C_W'(lf_dif_entry(g, FRAC_W));
   end

   logic             a_s, b_s, a_z, b_z;
   logic [MAG_W-1:0] a_m, b_m;

   assign a_s = a_i[MAG_W+1];
   assign b_s = b_i[MAG_W+1];
   assign a_z = a_i[MAG_W];
   assign b_z = b_i[MAG_W];
   assign a_m = a_i[MAG_W-1:0];
   assign b_m = b_i[MAG_W-1:0];

   // multiply: exponent addition with saturation
   logic [MAG_W:0]   prod;
   logic [LOG_W-1:0] mul_res;

   assign prod = {1'b0, a_m} + {1'b0, b_m};

   always_comb begin
      if (a_z || b_z)    mul_res = ZERO_W;
      else if (prod[MAG_W]) mul_res = {a_s ^ b_s, 1'b0, {MAG_W{1'b1}}};
      else               mul_res = {a_s ^ b_s, 1'b0, prod[MAG_W-1:0]};
   end

   // add: first adder orders and differences, second applies the correction
   logic             a_ge;
   logic [MAG_W-1:0] big, sml, diff;
   logic             big_s;
   logic [C_W-1:0]   up_sum;
   logic [LOG_W-1:0] add_res;

   assign a_ge   = (a_m >= b_m);
   assign big    = a_ge ? a_m : b_m;
   assign sml    = a_ge ? b_m : a_m;
   assign big_s  = a_ge ? a_s : b_s;
   assign diff   = big - sml;
   assign up_sum = C_W'(big) + sum_tbl[diff];

   always_comb begin
      if (a_z && b_z) begin
         add_res = ZERO_W;
      end else if (a_z) begin
         add_res = b_i;
      end else if (b_z) begin
         add_res = a_i;
      end else if (a_s == b_s) begin
         if (up_sum > C_W'(MAG_MAX)) add_res = {big_s, 1'b0, {MAG_W{1'b1}}};
         else                        add_res = {big_s, 1'b0, up_sum[MAG_W-1:0]};
      end else if (diff == '0) begin
         add_res = ZERO_W;
      end else if (dif_tbl[diff] > C_W'(big)) begin
         add_res = ZERO_W;
      end else begin
         add_res = {big_s, 1'b0, MAG_W'(C_W'(big) - dif_tbl[diff])};
      end
   end

   assign res_o = do_add ? add_res : mul_res;

endmodule

// File: rtl/logfmt_alu.sv
module logfmt_alu #(
   parameter int FIX_W  = 15,
   parameter int INT_W  = 3,
   parameter int FRAC_W = 3,
   parameter int ANTI_W = 8
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic [1:0]               op,
   input  logic [FIX_W-1:0]         fix_in,
   input  logic [INT_W+FRAC_W+1:0]  log_a,
   input  logic [INT_W+FRAC_W+1:0]  log_b,
   output logic                     out_valid,
   output logic [INT_W+FRAC_W+1:0]  log_out,
   output logic [FIX_W-1:0]         fix_out
);
   import logfmt_pkg::*;

   localparam int MAG_W = INT_W + FRAC_W;
   localparam int LOG_W = MAG_W + 2;
   localparam logic [LOG_W-1:0] ZERO_W = {1'b0, 1'b1, {MAG_W{1'b0}}};

   // elaboration-time parameter checks
   if (INT_W < 1 || FRAC_W < 1) begin : g_bad_log_w
      $error("logfmt_alu: INT_W and FRAC_W must be at least 1");
   end
   if (FIX_W < (1 << INT_W) + 2) begin : g_bad_fix_w
      $error("logfmt_alu: FIX_W too narrow for the decoded log range");
   end
   if (ANTI_W < FRAC_W) begin : g_bad_anti_w
      $error("logfmt_alu: ANTI_W must be at least FRAC_W");
   end

   // stage 1: operand capture
   logic             v1;
   lf_op_e           op1;
   logic [FIX_W-1:0] fix1;
   logic [LOG_W-1:0] a1, b1;

   always_ff @(posedge clk) begin
      if (rst) begin
         v1   <= 1'b0;
         op1  <= OP_TO_LOG;
         fix1 <= '0;
         a1   <= '0;
         b1   <= '0;
      end else begin
         v1 <= in_valid;
         if (in_valid) begin
            op1  <= lf_op_e'(op);
            fix1 <= fix_in;
            a1   <= log_a;
            b1   <= log_b;
         end
      end
   end

   logic [LOG_W-1:0] to_log_w, arith_w;
   logic [FIX_W-1:0] to_fix_w;

   logfmt_to_log #(.FIX_W(FIX_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_to_log (
      .fix_i (fix1),
      .log_o (to_log_w)
   );

   logfmt_to_fix #(.FIX_W(FIX_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .ANTI_W(ANTI_W)) u_to_fix (
      .log_i (a1),
      .fix_o (to_fix_w)
   );

   logfmt_arith #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_arith (
      .do_add (op1 == OP_ADD),
      .a_i    (a1),
      .b_i    (b1),
      .res_o  (arith_w)
   );

   logic [LOG_W-1:0] log_n;
   logic [FIX_W-1:0] fix_n;

   always_comb begin
      log_n = '0;
      fix_n = '0;
      unique case (op1)
         OP_TO_LOG: log_n = to_log_w;
         OP_TO_FIX: fix_n = to_fix_w;
         default:   log_n = arith_w;
      endcase
   end

   // stage 2: result register
   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         log_out   <= '0;
         fix_out   <= '0;
      end else begin
         out_valid <= v1;
         if (v1) begin
            log_out <= log_n;
            fix_out <= fix_n;
         end
      end
   end

   // ---------------- assertions ----------------
   assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> ##1 out_valid);

   assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ##1 !out_valid);

   assert_zero_canon_R2: assert property (@(posedge clk) disable iff (rst)
      (out_valid && log_out[MAG_W]) |-> (log_out == ZERO_W));

   assert_to_log_zero_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op == OP_TO_LOG && fix_in == '0) |=> ##1 (log_out == ZERO_W));

   assert_to_fix_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op == OP_TO_FIX && log_a[MAG_W]) |=> ##1 (fix_out == '0));

   assert_mul_zero_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op == OP_MUL && (log_a[MAG_W] || log_b[MAG_W]))
      |=> ##1 (log_out == ZERO_W));

   assert_cancel_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op == OP_ADD && !log_a[MAG_W] && !log_b[MAG_W]
       && (log_a[MAG_W+1] != log_b[MAG_W+1])
       && (log_a[MAG_W-1:0] == log_b[MAG_W-1:0]))
      |=> ##1 (log_out == ZERO_W));

   assert_unused_log_R9: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op == OP_TO_FIX) |=> ##1 (log_out == '0));

   assert_unused_fix_R9: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op != OP_TO_FIX) |=> ##1 (fix_out == '0));

endmodule

// File: tb/logfmt_alu_tb_top.sv
module logfmt_alu_tb_top;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [1:0]  op;
   logic [14:0] fix_in;
   logic [7:0]  log_a, log_b;
   logic        out_valid;
   logic [7:0]  log_out;
   logic [14:0] fix_out;

   always #5 clk = ~clk;

   logfmt_alu dut_i (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .op        (op),
      .fix_in    (fix_in),
      .log_a     (log_a),
      .log_b     (log_b),
      .out_valid (out_valid),
      .log_out   (log_out),
      .fix_out   (fix_out)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // two-slot queue of expected results
   logic        pv [2];
   logic [7:0]  pl [2];
   logic [14:0] pf [2];
   string       pt [2];

   // ---------------- reference model ----------------
   function automatic int rnd(input real x);
      return $rtoi($floor(x + 0.5));
   endfunction

   function automatic real lg2(input real x);
      return $ln(x) / $ln(2.0);
   endfunction

   function automatic logic [7:0] ref_to_log(input int x);
      int m, p, k, c;
      logic s;
      if (x == 0) return 8'h40;
      s = (x < 0);
      m = s ? -x : x;
      p = 0;
      for (int i = 0; i < 15; i++) if ((m >> i) & 1) p = i;
      if (p > 7) return {s, 1'b0, 6'h3F};
      k = ((m << 3) >> p) & 7;
      c = p * 8 + rnd(8.0 * lg2(1.0 + real'(k) / 8.0));
      return {s, 1'b0, 6'(c)};
   endfunction

   function automatic logic [14:0] ref_to_fix(input logic [7:0] w);
      int i, f, a, v;
      if (w[6]) return 15'd0;
      i = int'(w[5:3]);
      f = int'(w[2:0]);
      a = rnd(256.0 * ($pow(2.0, real'(f) / 8.0) - 1.0));
      v = ((256 + a) << i) >> 8;
      return w[7] ? 15'(-v) : 15'(v);
   endfunction

   function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
      int s;
      if (a[6] || b[6]) return 8'h40;
      s = int'(a[5:0]) + int'(b[5:0]);
      if (s > 63) s = 63;
      return {a[7] ^ b[7], 1'b0, 6'(s)};
   endfunction

   function automatic logic [7:0] ref_add(input logic [7:0] a, input logic [7:0] b);
      int ma, mb, big, sml, d, r;
      logic bs;
      if (a[6] && b[6]) return 8'h40;
      if (a[6]) return b;
      if (b[6]) return a;
      ma = int'(a[5:0]);
      mb = int'(b[5:0]);
      big = (ma >= mb) ? ma : mb;
      sml = (ma >= mb) ? mb : ma;
      bs  = (ma >= mb) ? a[7] : b[7];
      d   = big - sml;
      if (a[7] == b[7]) begin
         r = big + rnd(8.0 * lg2(1.0 + $pow(2.0, -real'(d) / 8.0)));
         if (r > 63) r = 63;
         return {bs, 1'b0, 6'(r)};
      end
      if (d == 0) return 8'h40;
      r = big + rnd(8.0 * lg2(1.0 - $pow(2.0, -real'(d) / 8.0)));
      if (r < 0) return 8'h40;
      return {bs, 1'b0, 6'(r)};
   endfunction

   function automatic string add_tag(input logic [7:0] a, input logic [7:0] b);
      if (a[6] || b[6]) return "R8";
      if (a[7] == b[7]) return "R6";
      return "R7";
   endfunction

   function automatic logic [7:0] canon(input int idx);
      if (idx == 0) return 8'h40;
      if (idx <= 64) return {2'b00, 6'(idx - 1)};
      return {2'b10, 6'(idx - 65)};
   endfunction

   // ---------------- stimulus helpers ----------------
   task automatic step(input logic v, input logic [1:0] o, input logic [14:0] fx,
                       input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] el, input logic [14:0] ef, input string tag);
      @(negedge clk);
      if (pv[1]) begin
         n_tests++;
         if (out_valid !== 1'b1 || log_out !== pl[1] || fix_out !== pf[1]) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b log=%h fix=%h, expected valid=1 log=%h fix=%h",
                     pt[1], out_valid, log_out, fix_out, pl[1], pf[1]);
         end
      end
      pv[1] = pv[0]; pl[1] = pl[0]; pf[1] = pf[0]; pt[1] = pt[0];
      pv[0] = v;     pl[0] = el;    pf[0] = ef;    pt[0] = tag;
      in_valid = v;
      op       = o;
      fix_in   = fx;
      log_a    = a;
      log_b    = b;
   endtask

   task automatic flush();
      step(1'b0, 2'd0, 15'd0, 8'd0, 8'd0, 8'd0, 15'd0, "");
      step(1'b0, 2'd0, 15'd0, 8'd0, 8'd0, 8'd0, 15'd0, "");
   endtask

   task automatic check1(input logic ok, input string tag, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %h, expected %h", tag, what, got, exp);
      end
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset_R10();
      rst = 1'b1; in_valid = 1'b0; op = 2'd0; fix_in = '0; log_a = '0; log_b = '0;
      pv[0] = 1'b0; pv[1] = 1'b0;
      repeat (3) @(negedge clk);
      check1(out_valid === 1'b0, "R10", "out_valid in reset", 16'(out_valid), 16'd0);
      rst = 1'b0;
      @(negedge clk);
      check1(out_valid === 1'b0, "R10", "out_valid", 16'(out_valid), 16'd0);
      check1(log_out === 8'h00, "R10", "log_out", 16'(log_out), 16'd0);
      check1(fix_out === 15'd0, "R10", "fix_out", 16'(fix_out), 16'd0);
   endtask

   task automatic t_corners();
      step(1, 2'd3, 0, 8'hFF, 8'h05, 8'h05, 0, "R8 noncanonical zero add");
      step(1, 2'd2, 0, 8'h7F, 8'h85, 8'h40, 0, "R5 noncanonical zero mul");
      step(1, 2'd1, 0, 8'hC7, 8'h00, 8'h00, 15'd0, "R4 zero flag decode");
      step(1, 2'd0, 15'h4000, 0, 0, 8'hBF, 0, "R3 most negative saturates");
      step(1, 2'd3, 0, 8'h3F, 8'h3F, 8'h3F, 0, "R6 sum saturates");
      step(1, 2'd3, 0, 8'h08, 8'h88, 8'h40, 0, "R7 exact cancel");
      step(1, 2'd3, 0, 8'h01, 8'h80, 8'h40, 0, "R7 underflow to zero");
      step(1, 2'd1, 0, 8'h3F, 8'h00, 8'h00, 15'd235, "R4 largest code");
      step(1, 2'd1, 0, 8'h00, 8'h00, 8'h00, 15'd1, "R4 smallest code");
      step(1, 2'd0, 15'd1, 0, 0, 8'h00, 0, "R3 one");
      step(1, 2'd0, 15'd255, 0, 0, 8'h3F, 0, "R3 top of range");
      step(1, 2'd0, 15'd256, 0, 0, 8'h3F, 0, "R3 first saturating");
      step(1, 2'd0, 15'h7FFD, 0, 0, 8'h8D, 0, "R3 minus three");
      step(1, 2'd2, 0, 8'h30, 8'hB0, 8'hBF, 0, "R5 product saturates R2");
      step(1, 2'd3, 0, 8'h40, 8'hC0, 8'h40, 0, "R8 two zeros");
      flush();
   endtask

   task automatic t_to_log_sweep_R3();
      for (int x = -16384; x < 16384; x++)
         step(1, 2'd0, 15'(x), 0, 0, ref_to_log(x), 15'd0, "R3 sweep");
      flush();
   endtask

   task automatic t_to_fix_sweep_R4();
      for (int w = 0; w < 256; w++)
         step(1, 2'd1, 0, 8'(w), 8'h00, 8'h00, ref_to_fix(8'(w)), "R4 R9 sweep");
      flush();
   endtask

   task automatic t_mul_sweep_R5();
      for (int i = 0; i < 129; i++)
         for (int j = 0; j < 129; j++)
            step(1, 2'd2, 0, canon(i), canon(j), ref_mul(canon(i), canon(j)), 15'd0, "R5 sweep");
      flush();
   endtask

   task automatic t_add_sweep();
      for (int i = 0; i < 129; i++)
         for (int j = 0; j < 129; j++)
            step(1, 2'd3, 0, canon(i), canon(j), ref_add(canon(i), canon(j)), 15'd0,
                 add_tag(canon(i), canon(j)));
      flush();
   endtask

   task automatic t_latency_R1();
      @(negedge clk);
      in_valid = 1'b1; op = 2'd2; log_a = 8'h09; log_b = 8'h8A; fix_in = '0;
      @(negedge clk);
      in_valid = 1'b0;
      check1(out_valid === 1'b0, "R1", "valid after one edge", 16'(out_valid), 16'd0);
      @(negedge clk);
      check1(out_valid === 1'b1, "R1", "valid after two edges", 16'(out_valid), 16'd1);
      check1(log_out === 8'h93, "R1", "result after two edges", 16'(log_out), 16'h93);
      @(negedge clk);
      check1(out_valid === 1'b0, "R1", "valid after three edges", 16'(out_valid), 16'd0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      t_reset_R10();
      t_corners();
      t_to_log_sweep_R3();
      t_to_fix_sweep_R4();
      t_mul_sweep_R5();
      t_add_sweep();
      t_latency_R1();
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL R1 watchdog: got no completion, expected completion within 200000 cycles");
         finish_run();
      end
   end

endmodule